// File: doc/BRIEF.md
# Condition Code Register with Interrupt Acceptance Gate

This block holds the status byte of an 8-bit processor core. After each datapath operation it takes the 8-bit result, the two operands, the nibble and byte carry/borrow bits from the adder, the shift-out bit and an operation class. From these it updates five result flags: half-carry, negative, zero, overflow and carry. Each operation class touches only the flags that mean something for it.

The same byte holds an interrupt enable bit and a 2-bit current interrupt level, and the CPU writes them through a direct load port. A pending interrupt request carries its own 2-bit level. The gate compares that level with the held state and raises an accept signal in the same cycle. Level code 0 is the most urgent and code 3 the least, so a request at code 3 is never taken. A direct load in the same cycle as a flag update wins over the update.

Top module: `ccr_gate`

## Requirements
- R1: While `rst_n` is low at a clock edge, the whole status byte is cleared. Interrupts are then disabled, the level is 00 and every flag is 0.
- R2: The status byte layout is: bit 7 interrupt enable, bits 6:5 current level, bit 4 H, bit 3 N, bit 2 Z, bit 1 V, bit 0 C. With `wr_en` high, the byte takes `wr_data` at the next edge, whatever the operation class.
- R3: For add, subtract, shift and logic, N takes result bit 7 and Z is 1 exactly when the result is zero.
- R4: For add and subtract, H takes `cy_nib`, the carry from bit 3 into bit 4 or the borrow from bit 4 into bit 3. For shift and logic, H keeps its value.
- R5: For add and subtract, C takes `cy_out`, the carry out of or borrow into bit 7. For shift, C takes `shift_out`. For logic, C keeps its value.
- R6: V is set on two's complement overflow of `opa + opb` for add and of `opa - opb` for subtract, and cleared otherwise. Shift and logic clear V.
- R7: Operation class codes are 000 none, 001 add, 010 subtract, 011 shift and 100 logic. With code 000, any unused code, or no write, the status byte is unchanged. Only a direct load changes the enable and level bits.
- R8: `irq_take` is 1 in the same cycle exactly when `irq_req` is 1, the enable bit is 1 and `irq_lvl` is numerically less than the held level. A request at level 11, or any request while the enable bit is 0, is never taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_cls | input | 3 | Operation class code |
| res | input | 8 | Datapath result |
| opa | input | 8 | First operand |
| opb | input | 8 | Second operand (subtrahend for subtract) |
| cy_nib | input | 1 | Nibble carry/borrow from the adder |
| cy_out | input | 1 | Byte carry/borrow from the adder |
| shift_out | input | 1 | Bit shifted out by a shift |
| wr_en | input | 1 | Direct load of the status byte |
| wr_data | input | 8 | Value for the direct load |
| irq_req | input | 1 | Interrupt request pending |
| irq_lvl | input | 2 | Level of the pending request |
| ccr_q | output | 8 | Current status byte |
| irq_take | output | 1 | Request accepted |

## Verification
Some rules are checked by assertions on every cycle:
- the reset value, and the load of written data;
- the unchanged byte on idle classes;
- the H and C hold on logic operations, and the V clear on shift and logic;
- the zero flag against the result;
- the block on level-3 requests and on requests while interrupts are disabled.

Other behaviour only the bench scenarios can show:
- the carry, borrow and overflow values, which need an independent adder model;
- C taking the shift-out bit;
- a load winning over a same-cycle flag update;
- the strict less-than comparison at each level boundary.

// File: rtl/ccr_pkg.sv
// Shared definitions for the status byte: operation classes, field positions
// and the flag record. Assumes the fixed byte layout given in the brief.
package ccr_pkg;

    localparam int LVL_W  = 2;
    localparam int CCR_W  = 1 + LVL_W + 5;

    localparam int POS_C  = 0;
    localparam int POS_V  = 1;
    localparam int POS_Z  = 2;
    localparam int POS_N  = 3;
    localparam int POS_H  = 4;
    localparam int POS_LV = 5;
    localparam int POS_IE = POS_LV + LVL_W;

    typedef enum logic [2:0] {
        OPC_NONE  = 3'd0,
        OPC_ADD   = 3'd1,
        OPC_SUB   = 3'd2,
        OPC_SHIFT = 3'd3,
        OPC_LOGIC = 3'd4
    } op_cls_e;

    typedef struct packed {
        logic h;
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

endpackage

// File: rtl/ccr_ovf.sv
// Two's complement overflow detector for add or subtract of two DW-bit
// operands. It recomputes the sign-extended sum or difference, so the answer
// does not depend on the result bus. Assumes DW >= 2.
module ccr_ovf #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          is_sub,
    output logic          ovf
);
    localparam int EW = DW + 1;

    logic [EW-1:0] ext_a;
    logic [EW-1:0] ext_b;
    logic [EW-1:0] wide;

    // Sign-extend both operands and form the sum or difference one bit wider.
    always_comb begin
        ext_a = {a[DW-1], a};
        ext_b = {b[DW-1], b};
        wide  = is_sub ? (ext_a - ext_b) : (ext_a + ext_b);
        ovf   = wide[EW-1] ^ wide[EW-2];
    end
endmodule

// File: rtl/ccr_flag_calc.sv
// Next-flag selector. It picks the new H, N, Z, V and C from the operation
// class and the datapath side signals, and keeps the flags a class does not
// own. Assumes the overflow bit has already been computed for add/sub.
module ccr_flag_calc #(
    parameter int DW = 8
) (
    input  ccr_pkg::op_cls_e op,
    input  logic [DW-1:0]    res,
    input  logic             cy_nib,
    input  logic             cy_out,
    input  logic             shift_out,
    input  logic             ovf,
    input  ccr_pkg::flags_t  cur,
    output ccr_pkg::flags_t  nxt
);
    import ccr_pkg::*;

    logic res_zero;
    logic res_neg;

    // Result-derived flags shared by every updating class.
    always_comb begin
        res_zero = ~|res;
        res_neg  = res[DW-1];
    end

    // Class-specific flag selection.
    always_comb begin
        nxt = cur;
        unique case (op)
            OPC_ADD, OPC_SUB: begin
                nxt.h = cy_nib;
                nxt.n = res_neg;
                nxt.z = res_zero;
                nxt.v = ovf;
                nxt.c = cy_out;
            end
            OPC_SHIFT: begin
                nxt.n = res_neg;
                nxt.z = res_zero;
                nxt.v = 1'b0;
                nxt.c = shift_out;
            end
            OPC_LOGIC: begin
                nxt.n = res_neg;
                nxt.z = res_zero;
                nxt.v = 1'b0;
            end
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/ccr_irq_gate.sv
// Interrupt acceptance compare. A request is taken when interrupts are
// enabled and its level code is strictly below the held level code.
// Assumes lower codes are more urgent.
module ccr_irq_gate #(
    parameter int LW = 2
) (
    input  logic          req,
    input  logic [LW-1:0] req_lvl,
    input  logic          ie,
    input  logic [LW-1:0] cur_lvl,
    output logic          take
);
    // Combinational gate on the held state.
    always_comb begin
        take = req & ie & (req_lvl < cur_lvl);
    end
endmodule

// File: rtl/ccr_gate.sv
// Status byte register with flag update and interrupt acceptance.
// Holds enable, level and five result flags. A direct load wins over a flag
// update, and only a direct load changes the enable and level fields.
// Assumes a synchronous active-low reset.
module ccr_gate #(
    parameter int DW = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [2:0]                op_cls,
    input  logic [DW-1:0]             res,
    input  logic [DW-1:0]             opa,
    input  logic [DW-1:0]             opb,
    input  logic                      cy_nib,
    input  logic                      cy_out,
    input  logic                      shift_out,
    input  logic                      wr_en,
    input  logic [ccr_pkg::CCR_W-1:0] wr_data,
    input  logic                      irq_req,
    input  logic [ccr_pkg::LVL_W-1:0] irq_lvl,
    output logic [ccr_pkg::CCR_W-1:0] ccr_q,
    output logic                      irq_take
);
    import ccr_pkg::*;

    op_cls_e          op;
    logic             ie_q;
    logic [LVL_W-1:0] lvl_q;
    flags_t           fl_q;
    flags_t           fl_nxt;
    logic             ovf;

    // Decode the raw class code; unused codes act as no-change.
    always_comb begin
        case (op_cls)
            3'd1:    op = OPC_ADD;
            3'd2:    op = OPC_SUB;
            3'd3:    op = OPC_SHIFT;
            3'd4:    op = OPC_LOGIC;
            default: op = OPC_NONE;
        endcase
    end

    ccr_ovf #(.DW(DW)) u_ovf (
        .a      (opa),
        .b      (opb),
        .is_sub (op == OPC_SUB),
        .ovf    (ovf)
    );

    ccr_flag_calc #(.DW(DW)) u_calc (
        .op        (op),
        .res       (res),
        .cy_nib    (cy_nib),
        .cy_out    (cy_out),
        .shift_out (shift_out),
        .ovf       (ovf),
        .cur       (fl_q),
        .nxt       (fl_nxt)
    );

    // Status byte register: reset, then direct load, then flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q  <= 1'b0;
            lvl_q <= '0;
            fl_q  <= '0;
        end else if (wr_en) begin
            ie_q  <= wr_data[POS_IE];
            lvl_q <= wr_data[POS_LV +: LVL_W];
            fl_q  <= flags_t'(wr_data[POS_H:POS_C]);
        end else begin
            fl_q  <= fl_nxt;
        end
    end

    // Pack the fields into the visible byte.
    always_comb begin
        ccr_q = {ie_q, lvl_q, fl_q};
    end

    ccr_irq_gate #(.LW(LVL_W)) u_irq (
        .req     (irq_req),
        .req_lvl (irq_lvl),
        .ie      (ie_q),
        .cur_lvl (lvl_q),
        .take    (irq_take)
    );
endmodule

// File: rtl/ccr_gate_chk.sv
// Cycle-by-cycle property checker for ccr_gate, attached by bind.
// Assumes the byte layout and class codes given in the brief.
module ccr_gate_chk #(
    parameter int DW = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [2:0]                op_cls,
    input logic [DW-1:0]             res,
    input logic                      wr_en,
    input logic [ccr_pkg::CCR_W-1:0] wr_data,
    input logic [ccr_pkg::LVL_W-1:0] irq_lvl,
    input logic [ccr_pkg::CCR_W-1:0] ccr_q,
    input logic                      irq_take
);
    import ccr_pkg::*;

    logic upd;
    logic nonarith;

    // Classify the current cycle for the properties below.
    always_comb begin
        upd      = !wr_en && (op_cls >= 3'd1) && (op_cls <= 3'd4);
        nonarith = !wr_en && (op_cls == 3'd3 || op_cls == 3'd4);
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ccr_q == '0);

    // R2
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ccr_q == $past(wr_data));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !(op_cls >= 3'd1 && op_cls <= 3'd4)) |=> $stable(ccr_q));

    // R3
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> ccr_q[POS_Z] == ($past(res) == '0));

    // R4
    half_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nonarith |=> $stable(ccr_q[POS_H]));

    // R5
    logic_carry_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && op_cls == 3'd4) |=> $stable(ccr_q[POS_C]));

    // R6
    nonarith_v_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nonarith |=> !ccr_q[POS_V]);

    // R7
    ctrl_field_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ccr_q[CCR_W-1:POS_LV]));

    // R8
    low_level_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_lvl == '1 |-> !irq_take);

    // R8
    disabled_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ccr_q[POS_IE] |-> !irq_take);
endmodule

bind ccr_gate ccr_gate_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_cls   (op_cls),
    .res      (res),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .irq_lvl  (irq_lvl),
    .ccr_q    (ccr_q),
    .irq_take (irq_take)
);

// File: tb/ccr_gate_tb.sv
// Scoreboard bench: driver tasks push expected bytes, a monitor pops and
// compares one cycle after each applied operation.
module ccr_gate_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op_cls = 3'd0;
    logic [7:0] res = 8'd0, opa = 8'd0, opb = 8'd0;
    logic       cy_nib = 1'b0, cy_out = 1'b0, shift_out = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic       irq_req = 1'b0;
    logic [1:0] irq_lvl = 2'd0;
    logic [7:0] ccr_q;
    logic       irq_take;

    int checks = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t      sb[$];
    logic [7:0] model = 8'd0;

    always #2 clk = ~clk;

    ccr_gate u_dut (
        .clk(clk), .rst_n(rst_n), .op_cls(op_cls), .res(res), .opa(opa),
        .opb(opb), .cy_nib(cy_nib), .cy_out(cy_out), .shift_out(shift_out),
        .wr_en(wr_en), .wr_data(wr_data), .irq_req(irq_req),
        .irq_lvl(irq_lvl), .ccr_q(ccr_q), .irq_take(irq_take)
    );

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Monitor: compare the byte just after the edge that follows a push.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check8(it.tag, ccr_q, it.exp);
        end
    end

    // Driver: apply one cycle of stimulus, push the expected byte, then idle.
    task automatic apply(input logic [2:0] op, input logic [7:0] r,
                         input logic [7:0] a, input logic [7:0] b,
                         input logic hn, input logic co, input logic so,
                         input logic we, input logic [7:0] wd,
                         input logic [7:0] exp, input string tag);
        @(negedge clk);
        op_cls = op; res = r; opa = a; opb = b;
        cy_nib = hn; cy_out = co; shift_out = so;
        wr_en = we; wr_data = wd;
        model = exp;
        sb.push_back('{exp, tag});
        @(negedge clk);
        op_cls = 3'd0; wr_en = 1'b0;
    endtask

    // Flag bits of the model: [4] H [3] N [2] Z [1] V [0] C.
    task automatic do_add(input logic [7:0] a, input logic [7:0] b, input string tag);
        logic [8:0] s;
        logic hn;
        int sv;
        logic [7:0] e;
        s  = {1'b0, a} + {1'b0, b};
        hn = ({1'b0, a[3:0]} + {1'b0, b[3:0]}) > 5'd15;
        sv = int'($signed(a)) + int'($signed(b));
        e  = {model[7:5], hn, s[7], s[7:0] == 8'd0, (sv > 127 || sv < -128), s[8]};
        apply(3'd1, s[7:0], a, b, hn, s[8], 1'b0, 1'b0, 8'd0, e, tag);
    endtask

    task automatic do_sub(input logic [7:0] a, input logic [7:0] b, input string tag);
        logic [7:0] d;
        logic hn, bo;
        int sv;
        logic [7:0] e;
        d  = a - b;
        hn = a[3:0] < b[3:0];
        bo = a < b;
        sv = int'($signed(a)) - int'($signed(b));
        e  = {model[7:5], hn, d[7], d == 8'd0, (sv > 127 || sv < -128), bo};
        apply(3'd2, d, a, b, hn, bo, 1'b0, 1'b0, 8'd0, e, tag);
    endtask

    task automatic chk_irq(input logic rq, input logic [1:0] lv, input logic exp, input string tag);
        @(negedge clk);
        irq_req = rq; irq_lvl = lv;
        #1;
        checks++;
        if (irq_take !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, irq_take, exp);
        end
        irq_req = 1'b0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            checks++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check8("R1 reset byte", ccr_q, 8'h00);
        rst_n = 1'b1;
        model = 8'h00;

        // R6 add overflow; R5 carry; R4 half carry; R3 N and Z
        do_add(8'h7F, 8'h01, "R6 add overflow 7F+01");
        do_add(8'hFF, 8'h01, "R5 add carry to zero FF+01");
        do_add(8'h12, 8'h34, "R3 add plain 12+34");
        do_add(8'h80, 8'h80, "R6 add negative overflow 80+80");
        do_sub(8'h10, 8'h01, "R4 sub nibble borrow 10-01");
        do_sub(8'h00, 8'h01, "R5 sub borrow 00-01");
        do_sub(8'h80, 8'h01, "R6 sub overflow 80-01");
        do_sub(8'h55, 8'h55, "R3 sub zero 55-55");
        // R5 shift carry from shift-out; R6 V clear; R4 H kept
        apply(3'd0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h13, 8'h13, "R2 load H V C");
        apply(3'd3, 8'h40, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h10, "R5 shift out zero");
        apply(3'd3, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h15, "R5 shift out one");
        // R5 logic keeps C and H, clears V
        apply(3'd0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h13, 8'h13, "R2 reload");
        apply(3'd4, 8'h80, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h19, "R5 logic keep C H");
        // R7 idle classes, including an unused code
        apply(3'd0, 8'h00, 8'h7F, 8'h01, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'h19, "R7 class none");
        apply(3'd6, 8'h00, 8'h7F, 8'h01, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'h19, "R7 unused code");
        // R2 load wins over an add in the same cycle
        apply(3'd1, 8'h00, 8'hFF, 8'h01, 1'b1, 1'b1, 1'b0, 1'b1, 8'hC0, 8'hC0, "R2 load priority");
        // R7 arithmetic leaves enable and level alone
        do_add(8'h01, 8'h01, "R7 add keeps control");

        // R8 held enable=1, level=10
        chk_irq(1'b1, 2'b01, 1'b1, "R8 lvl01 under 10");
        chk_irq(1'b1, 2'b10, 1'b0, "R8 lvl10 equal 10");
        chk_irq(1'b1, 2'b11, 1'b0, "R8 lvl11 blocked");
        chk_irq(1'b0, 2'b00, 1'b0, "R8 no request");
        apply(3'd0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h60, 8'h60, "R2 load disabled lvl11");
        chk_irq(1'b1, 2'b00, 1'b0, "R8 disabled");
        apply(3'd0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'hE0, 8'hE0, "R2 load enabled lvl11");
        chk_irq(1'b1, 2'b10, 1'b1, "R8 lvl10 under 11");
        chk_irq(1'b1, 2'b11, 1'b0, "R8 lvl11 under 11");
        apply(3'd0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h80, 8'h80, "R2 load enabled lvl00");
        chk_irq(1'b1, 2'b00, 1'b0, "R8 lvl00 under 00");

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule